// File: doc/BRIEF.md
# Receive FIFO Batching Forwarder

This block takes characters from a serial receiver and hands them to a packet-oriented host link. Each incoming character is stored in a 256-entry FIFO. In low-latency mode every character leaves as a one-byte packet as soon as it has been stored. In batch mode the block holds data back. It releases a full-size packet once that many characters have built up, or it releases everything held once the line has been quiet for three character times. A character time is ten bit periods, and a bit period is counted in clocks by the `bitDiv` input.

Once a packet boundary has been decided, the packet leaves on a valid/ready byte stream and its final byte is marked. No further boundary is decided until that packet has fully drained. The full packet size is 64 bytes, or 63 bytes when `shortPkt` is high. Low-latency mode is switched on automatically when the configured line rate is below 40961 bps; above that rate software chooses the mode. A live occupancy count is always shown. A write-one flush empties the FIFO. A sticky flag records characters that were dropped because the FIFO was full.

Register writes use `regAddr`. Address 0 is the mode control, and bit 0 set to 1 requests low latency. Address 1 is the flush, and writing 1 in bit 0 empties the FIFO. The bit is self-clearing and is never held. Address 2 is the status, and writing 1 in bit 0 clears the overrun flag.

Top module: `rx_batch_fwd`

## Requirements
- R1: In low-latency mode (`lowLatency` = 1), every stored character is released as a packet of exactly one byte, and `pktLast` is asserted on that byte.
- R2: In batch mode with `shortPkt` = 0, a packet of exactly 64 bytes is released as soon as the FIFO holds 64 characters.
- R3: In batch mode with `shortPkt` = 1, the full packet size is 63 bytes.
- R4: In batch mode, if fewer than a full packet are held, they are released as one packet 30·`bitDiv` clocks after the last received character (three 10-bit characters), within 3 further clocks. They are never released earlier.
- R5: `lowLatency` reads 1 whenever `baudRate` < 40961, whatever has been written to address 0. At higher rates it follows the last value written to bit 0 of address 0, and that value is 0 after reset.
- R6: A write of 1 to bit 0 of address 1 empties the FIFO. `fifoCount` reads 0 and `pktValid` is low from the next clock, and no packet is later released from the flushed characters.
- R7: `fifoCount` (9 bits) gives the number of characters held, from 0 to 256. It reads 0 after reset.
- R8: While `pktValid` is high and `pktReady` is low, `pktData` and `pktLast` hold steady. Bytes leave in the order they arrived.
- R9: A character that arrives while 256 characters are held is dropped, and `overrun` is set. `overrun` stays set until a write of 1 to bit 0 of address 2, and that write does not change `fifoCount`.
- R10: A packet's length is fixed when it is released. Characters arriving during its drain are not added to it and go into a later packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Received character strobe |
| rxData | input | 8 | Received character |
| baudRate | input | 24 | Configured line rate in bps |
| bitDiv | input | 16 | Clocks per bit period for the idle timer |
| shortPkt | input | 1 | 1 selects 63-byte full packets |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 mode, 1 flush, 2 status) |
| regWrData | input | 8 | Register write data |
| pktValid | output | 1 | A released byte is offered |
| pktData | output | 8 | Offered byte |
| pktLast | output | 1 | Offered byte ends its packet |
| pktReady | input | 1 | Host accepts the offered byte |
| fifoCount | output | 9 | Characters currently held |
| lowLatency | output | 1 | Effective low-latency mode |
| overrun | output | 1 | Sticky dropped-character flag |

## Verification
The assertions check several properties on every cycle: that the occupancy never exceeds 256, that an offered byte and its last marker stay steady under back-pressure, that the mode is forced at low line rates, that a flush empties the FIFO on the next clock, and that a dropped character raises the overrun flag. The bench's scenarios are needed to show the packet sizes themselves. These are one-byte packets in low-latency mode, 64 or 63 bytes at the full threshold, and the idle release timed against 30 bit periods. They also show byte order across packets and that characters arriving mid-drain stay out of the packet being drained.

// File: rtl/rxfwd_pkg.sv
package rxfwd_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifoCtl_t;

  localparam logic [1:0] ADDR_MODE   = 2'd0;
  localparam logic [1:0] ADDR_FLUSH  = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;
endpackage

// File: rtl/rxfwd_datapath.sv
module rxfwd_datapath
  import rxfwd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCtl_t          ctl,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  count
);
  // DEPTH is a power of two, so the pointers wrap naturally.
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (ctl.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (ctl.push) wrPtr <= wrPtr + 1'b1;
      if (ctl.pop)  rdPtr <= rdPtr + 1'b1;
      count <= count + CNT_W'(ctl.push) - CNT_W'(ctl.pop);
    end
  end

  assign rdData = mem[rdPtr];
endmodule

// File: rtl/rxfwd_control.sv
module rxfwd_control
  import rxfwd_pkg::*;
#(
  parameter int DEPTH      = 256,
  parameter int PKT_MAX    = 64,
  parameter int DIV_W      = 16,
  parameter int BAUD_W     = 24,
  parameter int LL_BAUD    = 40961,
  parameter int CHAR_BITS  = 10,
  parameter int IDLE_CHARS = 3,
  localparam int CNT_W     = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [BAUD_W-1:0] baudRate,
  input  logic [DIV_W-1:0]  bitDiv,
  input  logic              shortPkt,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [7:0]        regWrData,
  input  logic              pktReady,
  input  logic [CNT_W-1:0]  count,
  output fifoCtl_t          ctl,
  output logic              pktValid,
  output logic              pktLast,
  output logic              lowLatency,
  output logic              overrun
);
  localparam int IDLE_BITS = CHAR_BITS * IDLE_CHARS;
  localparam int IDLE_W    = $clog2(IDLE_BITS + 1);

  logic              llReg;
  logic              full, flushReq, release_, timedOut, restart;
  logic [CNT_W-1:0]  drainRem, relLen, maxPkt;
  logic [DIV_W-1:0]  prescale, divLast;
  logic [IDLE_W-1:0] bitCnt;

  assign full       = (count == CNT_W'(DEPTH));
  assign flushReq   = regWr && (regAddr == ADDR_FLUSH) && regWrData[0];
  assign lowLatency = llReg || (baudRate < BAUD_W'(LL_BAUD));
  assign maxPkt     = shortPkt ? CNT_W'(PKT_MAX - 1) : CNT_W'(PKT_MAX);

  assign pktValid = (drainRem != '0);
  assign pktLast  = (drainRem == CNT_W'(1));

  assign ctl.flush = flushReq;
  assign ctl.push  = rxValid && !full && !flushReq;
  assign ctl.pop   = pktValid && pktReady && !flushReq;

  // Packet boundary decision, only while no packet is draining.
  always_comb begin
    relLen = '0;
    if (!pktValid && count != '0 && !flushReq) begin
      if (lowLatency)           relLen = CNT_W'(1);
      else if (count >= maxPkt) relLen = maxPkt;
      else if (timedOut)        relLen = count;
    end
  end
  assign release_ = (relLen != '0);

  always_ff @(posedge clk) begin
    if (!rstN || flushReq)   drainRem <= '0;
    else if (release_)       drainRem <= relLen;
    else if (ctl.pop)        drainRem <= drainRem - 1'b1;
  end

  // Idle timer: bit periods since the last character, armed while data is held.
  assign divLast  = (bitDiv == '0) ? '0 : bitDiv - 1'b1;
  assign timedOut = (bitCnt == IDLE_W'(IDLE_BITS));
  assign restart  = rxValid || (count == '0) || release_;

  always_ff @(posedge clk) begin
    if (!rstN || restart) begin
      prescale <= '0;
      bitCnt   <= '0;
    end else if (!timedOut) begin
      if (prescale >= divLast) begin
        prescale <= '0;
        bitCnt   <= bitCnt + 1'b1;
      end else begin
        prescale <= prescale + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      llReg   <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (regWr && regAddr == ADDR_MODE) llReg <= regWrData[0];
      if (rxValid && full)
        overrun <= 1'b1;
      else if (regWr && regAddr == ADDR_STATUS && regWrData[0])
        overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_batch_fwd.sv
module rx_batch_fwd
  import rxfwd_pkg::*;
#(
  parameter int DEPTH      = 256,
  parameter int PKT_MAX    = 64,
  parameter int DIV_W      = 16,
  parameter int BAUD_W     = 24,
  parameter int LL_BAUD    = 40961,
  parameter int CHAR_BITS  = 10,
  parameter int IDLE_CHARS = 3,
  localparam int CNT_W     = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic [BAUD_W-1:0] baudRate,
  input  logic [DIV_W-1:0]  bitDiv,
  input  logic              shortPkt,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [7:0]        regWrData,
  output logic              pktValid,
  output logic [7:0]        pktData,
  output logic              pktLast,
  input  logic              pktReady,
  output logic [CNT_W-1:0]  fifoCount,
  output logic              lowLatency,
  output logic              overrun
);
  fifoCtl_t ctl;

  rxfwd_datapath #(.DATA_W(8), .DEPTH(DEPTH)) dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(rxData),
    .rdData(pktData), .count(fifoCount)
  );

  rxfwd_control #(
    .DEPTH(DEPTH), .PKT_MAX(PKT_MAX), .DIV_W(DIV_W), .BAUD_W(BAUD_W),
    .LL_BAUD(LL_BAUD), .CHAR_BITS(CHAR_BITS), .IDLE_CHARS(IDLE_CHARS)
  ) ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .baudRate(baudRate),
    .bitDiv(bitDiv), .shortPkt(shortPkt), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .pktReady(pktReady), .count(fifoCount),
    .ctl(ctl), .pktValid(pktValid), .pktLast(pktLast),
    .lowLatency(lowLatency), .overrun(overrun)
  );
endmodule

// File: rtl/rx_batch_fwd_check.sv
module rx_batch_fwd_check #(
  parameter int DEPTH   = 256,
  parameter int BAUD_W  = 24,
  parameter int LL_BAUD = 40961,
  localparam int CNT_W  = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxValid,
  input logic [BAUD_W-1:0] baudRate,
  input logic              regWr,
  input logic [1:0]        regAddr,
  input logic [7:0]        regWrData,
  input logic              pktValid,
  input logic [7:0]        pktData,
  input logic              pktLast,
  input logic              pktReady,
  input logic [CNT_W-1:0]  fifoCount,
  input logic              lowLatency,
  input logic              overrun
);
  logic flushW;
  assign flushW = regWr && regAddr == 2'd1 && regWrData[0];

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(DEPTH));

  assert_last_needs_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    pktLast |-> pktValid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !pktReady && !flushW) |=>
      (pktValid && $stable(pktData) && $stable(pktLast)));

  assert_forced_ll_R5: assert property (@(posedge clk) disable iff (!rstN)
    (baudRate < BAUD_W'(LL_BAUD)) |-> lowLatency);

  assert_flush_R6: assert property (@(posedge clk) disable iff (!rstN)
    flushW |=> (fifoCount == '0 && !pktValid));

  assert_overrun_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && fifoCount == CNT_W'(DEPTH)) |=> (overrun && fifoCount == CNT_W'(DEPTH)));
endmodule

bind rx_batch_fwd rx_batch_fwd_check #(
  .DEPTH(DEPTH), .BAUD_W(BAUD_W), .LL_BAUD(LL_BAUD)
) chk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .baudRate(baudRate),
  .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
  .pktValid(pktValid), .pktData(pktData), .pktLast(pktLast),
  .pktReady(pktReady), .fifoCount(fifoCount), .lowLatency(lowLatency),
  .overrun(overrun)
);

// File: tb/rx_batch_fwd_test.sv
module rx_batch_fwd_test;
  localparam int DIV  = 4;
  localparam int IDLE = 30 * DIV;
  localparam int NV   = 4;
  // Each row: low-latency write, shortPkt, byte count, expected packet count.
  localparam int VEC [NV][4] = '{
    '{1, 0,   5, 5},
    '{0, 0,  70, 2},
    '{0, 1,  63, 1},
    '{0, 0, 130, 3}
  };

  logic clk = 0, rstN = 0;
  logic rxValid = 0; logic [7:0] rxData = 0;
  logic [23:0] baudRate = 24'd115200;
  logic [15:0] bitDiv = 16'(DIV);
  logic shortPkt = 0, regWr = 0; logic [1:0] regAddr = 0; logic [7:0] regWrData = 0;
  logic pktValid, pktLast, pktReady = 1; logic [7:0] pktData;
  logic [8:0] fifoCount; logic lowLatency, overrun;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] gotBytes [0:1023];
  int pktLen [0:63];
  int byteCnt = 0, pktCnt = 0, curLen = 0;

  always #4 clk = ~clk;

  rx_batch_fwd uut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .baudRate(baudRate), .bitDiv(bitDiv), .shortPkt(shortPkt),
    .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
    .pktValid(pktValid), .pktData(pktData), .pktLast(pktLast),
    .pktReady(pktReady), .fifoCount(fifoCount), .lowLatency(lowLatency),
    .overrun(overrun)
  );

  always @(negedge clk) begin
    if (rstN && pktValid && pktReady) begin
      if (byteCnt < 1024) gotBytes[byteCnt] = pktData;
      byteCnt++;
      curLen++;
      if (pktLast) begin
        if (pktCnt < 64) pktLen[pktCnt] = curLen;
        pktCnt++;
        curLen = 0;
      end
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic waitN(int n); repeat (n) tick(); endtask
  task automatic clearMon(); byteCnt = 0; pktCnt = 0; curLen = 0; endtask

  task automatic checkEq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sendByte(logic [7:0] b);
    rxValid = 1; rxData = b; tick(); rxValid = 0;
  endtask

  task automatic regWrite(logic [1:0] a, logic [7:0] d);
    regWr = 1; regAddr = a; regWrData = d; tick(); regWr = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int k;
    logic [7:0] held;
    waitN(3); rstN = 1; tick();
    // Reset state (R7, R5, R9)
    checkEq("R7 reset count", fifoCount, 0);
    checkEq("R5 reset mode", lowLatency, 0);
    checkEq("R9 reset overrun", overrun, 0);
    checkEq("R8 reset valid", pktValid, 0);

    // Vector table: R1, R2, R3, R10 packet sizes and ordering
    for (int v = 0; v < NV; v++) begin
      int maxP, n, expFirst;
      bit orderOk;
      regWrite(2'd0, 8'(VEC[v][0]));
      shortPkt = VEC[v][1][0];
      n = VEC[v][2];
      maxP = shortPkt ? 63 : 64;
      expFirst = VEC[v][0] ? 1 : (n >= maxP ? maxP : n);
      clearMon();
      for (int i = 0; i < n; i++) sendByte(8'(v * 16 + i));
      waitN(400);
      checkEq(VEC[v][0] ? "R1 packet count" : (shortPkt ? "R3 packet count" : "R2 packet count"),
              pktCnt, VEC[v][3]);
      checkEq(VEC[v][0] ? "R1 first length" : (shortPkt ? "R3 first length" : "R2 first length"),
              pktLen[0], expFirst);
      checkEq("R8 byte total", byteCnt, n);
      orderOk = 1;
      for (int i = 0; i < n; i++) if (gotBytes[i] != 8'(v * 16 + i)) orderOk = 0;
      checkEq("R8 byte order", orderOk, 1);
      checkEq("R7 drained count", fifoCount, 0);
    end
    regWrite(2'd0, 8'd0); shortPkt = 0;

    // R5 forced low latency
    baudRate = 24'd9600; #1;
    checkEq("R5 forced at 9600", lowLatency, 1);
    regWrite(2'd0, 8'd0);
    checkEq("R5 forced despite write 0", lowLatency, 1);
    clearMon();
    sendByte(8'h11); sendByte(8'h22); waitN(20);
    checkEq("R5 single-byte packets", pktCnt, 2);
    baudRate = 24'd40961; #1;
    checkEq("R5 software mode at 40961", lowLatency, 0);
    baudRate = 24'd115200;

    // R4 idle timeout timing
    clearMon();
    sendByte(8'h5A);
    k = 1;
    while (!pktValid && k < 1000) begin tick(); k++; end
    checkEq("R4 not before timeout", (k >= IDLE) ? 1 : 0, 1);
    checkEq("R4 by timeout plus 3", (k <= IDLE + 3) ? 1 : 0, 1);
    waitN(5);
    checkEq("R4 one-byte remainder", pktLen[0], 1);

    // R10 and R8: boundary fixed at release, hold under back-pressure
    pktReady = 0; clearMon();
    sendByte(8'hA0); sendByte(8'hA1); sendByte(8'hA2);
    waitN(IDLE + 10);
    checkEq("R10 packet offered", pktValid, 1);
    held = pktData;
    sendByte(8'hA3); sendByte(8'hA4);
    waitN(3);
    checkEq("R8 data held", pktData, held);
    checkEq("R8 first byte", held, 8'hA0);
    checkEq("R8 last low on first", pktLast, 0);
    pktReady = 1;
    waitN(IDLE + 20);
    checkEq("R10 two packets", pktCnt, 2);
    checkEq("R10 first length", pktLen[0], 3);
    checkEq("R10 second length", pktLen[1], 2);

    // R6 flush
    pktReady = 0; clearMon();
    for (int i = 0; i < 5; i++) sendByte(8'(i));
    waitN(IDLE + 10);
    checkEq("R6 pending before flush", pktValid, 1);
    regWrite(2'd1, 8'd1);
    checkEq("R6 count after flush", fifoCount, 0);
    checkEq("R6 valid after flush", pktValid, 0);
    pktReady = 1;
    waitN(IDLE + 20);
    checkEq("R6 nothing released", pktCnt, 0);

    // R9 overrun and R7 full count
    pktReady = 0;
    for (int i = 0; i < 260; i++) sendByte(8'(i));
    checkEq("R7 full count", fifoCount, 256);
    checkEq("R9 overrun set", overrun, 1);
    waitN(5);
    checkEq("R9 overrun sticky", overrun, 1);
    regWrite(2'd2, 8'd1);
    checkEq("R9 overrun cleared", overrun, 0);
    checkEq("R9 clear keeps count", fifoCount, 256);
    regWrite(2'd1, 8'd1);
    checkEq("R6 flush from full", fifoCount, 0);
    pktReady = 1;
    waitN(10);

    finishRun();
  end
endmodule